// File: doc/BRIEF.md
# Dual-Channel Down-Counting Event Timer

This block holds a set of independent timer channels behind a small memory-mapped register bus. Each channel has a control word, a live counter and a load value. While its tick selector is non-zero, the live counter drops by one on every `tick_i` pulse. When the counter reaches zero, the channel raises a sticky status flag. The flag reaches the channel's interrupt line only if that channel's interrupt enable is set. Software clears the flag by writing a zero to it.

A channel runs in one of two ways. In one-shot use it stops at zero and stays there until software gives it a new load value. In continuous use it loads its load value again on the tick after it reaches zero, so the period is the load value plus one tick. This makes it a free-running time base. Writing the load value while the channel's immediate-load bit is set copies the value into the counter in the same cycle, which starts a new countdown at once. A shared control word carries a self-clearing block reset. A read-only identity word reports the major revision in its top byte.

Bus writes take effect on the rising clock edge while `req_i` and `we_i` are both high. `rdata_o` follows `addr_i` combinationally. Unmapped addresses read as zero.

Top module: `tmr_block`

## Requirements
- R1: After reset every channel's control, count and load registers read zero, `irq_o` is zero, and the identity word at 0xA0 reads `MAJOR_REV << 24` (0x02000000 by default).
- R2: Channel n uses three addresses: control at 0x20+n*0x40, live count at 0x30+n*0x40 and load value at 0x40+n*0x40. The control word holds tick select in [3:0], continuous enable in [6], immediate load in [7], interrupt enable in [14] and status flag in [15]. Every other control bit reads zero.
- R3: When tick select is 0 the counter holds. When tick select is non-zero and the counter is non-zero, each `tick_i` pulse lowers the counter by exactly one.
- R4: On the tick that takes the counter from 1 to 0, status flag [15] sets whatever the enable bit holds. `irq_o[n]` is high exactly when flag and interrupt enable [14] are both set.
- R5: Writing 0 to control bit [15] clears the flag. Writing 1 to it leaves the flag unchanged.
- R6: With continuous enable set, a tick that finds the counter at zero loads the load value into the counter.
- R7: With continuous enable clear, the counter stays at zero on later ticks. A write to the load value while the counter is zero restarts the counter from the written value, even with immediate load clear.
- R8: With immediate load set, a load-value write is copied into the counter in the same cycle. With immediate load clear and the counter non-zero, the write changes only the load value.
- R9: The live count address is read-only: writes to it leave the counter unchanged.
- R10: Writing a 1 to bit 31 at shared address 0x00 returns every channel's control, count and load registers to zero in one cycle and drops `irq_o`.
- R11: A load-value write that loads the counter takes priority over a tick in the same cycle. The counter takes the written value and does not decrement.
- R12: An all-ones load value is loaded intact, and the next tick moves the counter to 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | AW (8) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tick_i | input | 1 | Tick-enable pulse shared by all channels |
| irq_o | output | NCH (2) | Per-channel interrupt: flag AND enable |

## Verification
The counting path is driven with short countdowns under four settings: stopped select, one-shot, continuous and immediate load. A short countdown ending at zero shows whether the flag fires on the 1-to-0 step and whether the channel then holds or reloads. Load-value writes are issued with and without the immediate-load bit, on a running counter and on an expired one, and also in the same cycle as a tick. These cases separate the write-priority and restart rules from plain counting. The all-ones load value and a second channel with its own select and enable show that the full counter width is kept and that the channels do not interact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW         = 32;
  localparam int SEL_W      = 4;
  localparam int RELOAD_BIT = 6;
  localparam int UPDATE_BIT = 7;
  localparam int IE_BIT     = 14;
  localparam int FLAG_BIT   = 15;
  localparam int SRST_BIT   = 31;
  localparam int CH_CTL_OFS = 'h20;
  localparam int CH_RUN_OFS = 'h30;
  localparam int CH_FIX_OFS = 'h40;
  localparam int CH_STRIDE  = 'h40;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic             update;
    logic             reload;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int AW        = 8,
  parameter int MAJOR_REV = 2
) (
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NCH-1:0][DW-1:0]  ctl_rd_i,
  input  logic [NCH-1:0][DW-1:0]  cnt_rd_i,
  input  logic [NCH-1:0][DW-1:0]  fix_rd_i,
  output logic [NCH-1:0]          wr_ctl_o,
  output logic [NCH-1:0]          wr_fix_o,
  output logic                    srst_o,
  output logic [DW-1:0]           rdata_o
);
  localparam int             VER_OFS = CH_CTL_OFS + NCH * CH_STRIDE;
  localparam logic [DW-1:0]  VER_VAL = DW'(MAJOR_REV) << 24;

  function automatic logic [AW-1:0] ch_addr(int base, int n);
    return AW'(base + n * CH_STRIDE);
  endfunction

  logic wr;
  assign wr     = req_i && we_i;
  assign srst_o = wr && (addr_i == '0) && wdata_i[SRST_BIT];

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign wr_ctl_o[n] = wr && (addr_i == ch_addr(CH_CTL_OFS, n));
    assign wr_fix_o[n] = wr && (addr_i == ch_addr(CH_FIX_OFS, n));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(VER_OFS)) rdata_o = VER_VAL;
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == ch_addr(CH_CTL_OFS, n)) rdata_o = ctl_rd_i[n];
      if (addr_i == ch_addr(CH_RUN_OFS, n)) rdata_o = cnt_rd_i[n];
      if (addr_i == ch_addr(CH_FIX_OFS, n)) rdata_o = fix_rd_i[n];
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          srst_i,
  input  logic          wr_ctl_i,
  input  logic          wr_fix_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctl_rd_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] fix_o,
  output logic          flag_o,
  output logic          ie_o,
  output logic          sel_nz_o,
  output logic          reload_o
);
  ctl_t          ctl_q, ctl_d;
  logic [CW-1:0] cnt_q, cnt_d, fix_q, fix_d;
  logic          load_fix, step, hit;
  logic          unused_wbits;

  assign unused_wbits = ^{wdata_i[DW-1:FLAG_BIT+1], wdata_i[IE_BIT-1:UPDATE_BIT+1],
                          wdata_i[RELOAD_BIT-1:SEL_W]};

  // write restarts the count when immediate load is on or a one-shot has expired
  assign load_fix = wr_fix_i && (ctl_q.update || (cnt_q == '0 && !ctl_q.reload));
  assign step     = tick_i && (ctl_q.sel != '0) && !load_fix;
  assign hit      = step && (cnt_q == CW'(1));

  always_comb begin
    ctl_d = ctl_q;
    fix_d = fix_q;
    cnt_d = cnt_q;
    if (wr_ctl_i) begin
      ctl_d.sel    = wdata_i[SEL_W-1:0];
      ctl_d.reload = wdata_i[RELOAD_BIT];
      ctl_d.update = wdata_i[UPDATE_BIT];
      ctl_d.ie     = wdata_i[IE_BIT];
      ctl_d.flag   = ctl_q.flag && wdata_i[FLAG_BIT];
    end
    if (hit) ctl_d.flag = 1'b1;
    if (wr_fix_i) fix_d = wdata_i[CW-1:0];
    if (load_fix) cnt_d = wdata_i[CW-1:0];
    else if (step) begin
      if (cnt_q != '0)        cnt_d = cnt_q - CW'(1);
      else if (ctl_q.reload)  cnt_d = fix_q;
    end
    if (srst_i) begin
      ctl_d = '0;
      fix_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      fix_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      fix_q <= fix_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    ctl_rd_o                   = '0;
    ctl_rd_o[SEL_W-1:0]        = ctl_q.sel;
    ctl_rd_o[RELOAD_BIT]       = ctl_q.reload;
    ctl_rd_o[UPDATE_BIT]       = ctl_q.update;
    ctl_rd_o[IE_BIT]           = ctl_q.ie;
    ctl_rd_o[FLAG_BIT]         = ctl_q.flag;
  end

  assign cnt_o    = cnt_q;
  assign fix_o    = fix_q;
  assign flag_o   = ctl_q.flag;
  assign ie_o     = ctl_q.ie;
  assign sel_nz_o = ctl_q.sel != '0;
  assign reload_o = ctl_q.reload;
endmodule

// File: rtl/tmr_block.sv
module tmr_block
  import tmr_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int CW        = 32,
  parameter int AW        = 8,
  parameter int MAJOR_REV = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic           tick_i,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0][DW-1:0] ctl_rd, cnt_rd, fix_rd;
  logic [NCH-1:0][CW-1:0] cnt_all, fix_all;
  logic [NCH-1:0]         wr_ctl, wr_fix, flag_v, ie_v, sel_nz_v, reload_v;
  logic                   srst;

  tmr_decode #(.NCH(NCH), .AW(AW), .MAJOR_REV(MAJOR_REV)) i_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ctl_rd_i (ctl_rd),
    .cnt_rd_i (cnt_rd),
    .fix_rd_i (fix_rd),
    .wr_ctl_o (wr_ctl),
    .wr_fix_o (wr_fix),
    .srst_o   (srst),
    .rdata_o  (rdata_o)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tmr_channel #(.CW(CW)) i_channel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .srst_i   (srst),
      .wr_ctl_i (wr_ctl[n]),
      .wr_fix_i (wr_fix[n]),
      .wdata_i  (wdata_i),
      .ctl_rd_o (ctl_rd[n]),
      .cnt_o    (cnt_all[n]),
      .fix_o    (fix_all[n]),
      .flag_o   (flag_v[n]),
      .ie_o     (ie_v[n]),
      .sel_nz_o (sel_nz_v[n]),
      .reload_o (reload_v[n])
    );
    assign cnt_rd[n] = DW'(cnt_all[n]);
    assign fix_rd[n] = DW'(fix_all[n]);
  end

  assign irq_o = flag_v & ie_v;
endmodule

// File: rtl/tmr_block_chk.sv
module tmr_block_chk #(
  parameter int NCH = 2,
  parameter int CW  = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick_i,
  input logic                   srst,
  input logic [NCH-1:0]         wr_fix,
  input logic [NCH-1:0]         sel_nz_v,
  input logic [NCH-1:0]         reload_v,
  input logic [NCH-1:0]         flag_v,
  input logic [NCH-1:0]         irq_o,
  input logic [NCH-1:0][CW-1:0] cnt_all
);
  for (genvar n = 0; n < NCH; n++) begin : g_chk
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && sel_nz_v[n] && cnt_all[n] != '0 && !wr_fix[n] && !srst
      |=> cnt_all[n] == $past(cnt_all[n]) - CW'(1)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_nz_v[n] && !wr_fix[n] && !srst |=> $stable(cnt_all[n])); // R3
    AST_FLAG_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_v[n]) |-> $past(tick_i) && $past(cnt_all[n]) == CW'(1) && cnt_all[n] == '0); // R4
    AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_all[n] == '0 && !reload_v[n] && !wr_fix[n] && !srst |=> cnt_all[n] == '0); // R7
    AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst |=> cnt_all[n] == '0 && !flag_v[n] && !irq_o[n]); // R10
  end
endmodule

bind tmr_block tmr_block_chk #(.NCH(NCH), .CW(CW)) i_tmr_block_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .srst     (srst),
  .wr_fix   (wr_fix),
  .sel_nz_v (sel_nz_v),
  .reload_v (reload_v),
  .flag_v   (flag_v),
  .irq_o    (irq_o),
  .cnt_all  (cnt_all)
);

// File: tb/test_tmr_block.sv
`timescale 1ns/1ps
module test_tmr_block;
  localparam logic [7:0] A_TOP = 8'h00, A_C0 = 8'h20, A_R0 = 8'h30, A_F0 = 8'h40;
  localparam logic [7:0] A_C1 = 8'h60, A_R1 = 8'h70, A_F1 = 8'h80, A_VER = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  irq;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tmr_block i_tmr_block (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string req_tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req_tag, rdata, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1", A_C0, 0); rd_chk("R1", A_R0, 0); rd_chk("R1", A_F0, 0);
    rd_chk("R1", A_C1, 0); rd_chk("R1", A_VER, 32'h0200_0000);
    chk("R1", {30'd0, irq}, 0);
  endtask

  task automatic t_map;
    wr(A_C0, 32'hFFFF_FFFF);
    rd_chk("R2", A_C0, 32'h0000_40CF); // flag cannot be set by software
    wr(A_C0, 0);
    rd_chk("R2", A_C0, 0);
  endtask

  task automatic t_count;
    wr(A_C0, 32'h81);
    wr(A_F0, 5);
    rd_chk("R8", A_R0, 5);
    ticks(2);
    rd_chk("R3", A_R0, 3);
    wr(A_C0, 32'h80);
    ticks(2);
    rd_chk("R3", A_R0, 3);
  endtask

  task automatic t_flag;
    wr(A_C0, 32'h81);
    wr(A_F0, 2);
    ticks(2);
    rd_chk("R4", A_R0, 0);
    rd_chk("R4", A_C0, 32'h8081);
    chk("R4", {31'd0, irq[0]}, 0);
    wr(A_C0, 32'hC081);
    chk("R4", {31'd0, irq[0]}, 1);
    rd_chk("R5", A_C0, 32'hC081);
    wr(A_C0, 32'h4081);
    rd_chk("R5", A_C0, 32'h4081);
    chk("R5", {31'd0, irq[0]}, 0);
  endtask

  task automatic t_oneshot;
    ticks(3);
    rd_chk("R7", A_R0, 0);
    rd_chk("R7", A_C0, 32'h4081); // no second flag at zero
    wr(A_C0, 32'h01);
    wr(A_F0, 4);
    rd_chk("R7", A_R0, 4);
    wr(A_F0, 9);
    rd_chk("R8", A_R0, 4);
    rd_chk("R8", A_F0, 9);
  endtask

  task automatic t_reload;
    wr(A_C0, 32'hC1);
    wr(A_F0, 2);
    ticks(2);
    rd_chk("R6", A_R0, 0);
    ticks(1);
    rd_chk("R6", A_R0, 2);
    ticks(3);
    rd_chk("R6", A_R0, 2);
    rd_chk("R6", A_C0, 32'h80C1);
    wr(A_C0, 32'hC1);
  endtask

  task automatic t_readonly;
    wr(A_R0, 32'h7);
    rd_chk("R9", A_R0, 2);
  endtask

  task automatic t_wide;
    wr(A_F0, 32'hFFFF_FFFF);
    rd_chk("R12", A_R0, 32'hFFFF_FFFF);
    ticks(1);
    rd_chk("R12", A_R0, 32'hFFFF_FFFE);
  endtask

  task automatic t_priority;
    @(negedge clk); req = 1'b1; we = 1'b1; addr = A_F0; wdata = 10; tick = 1'b1;
    @(negedge clk); req = 1'b0; we = 1'b0; tick = 1'b0;
    rd_chk("R11", A_R0, 10);
  endtask

  task automatic t_chan1;
    wr(A_C0, 32'h80);  // park channel 0
    wr(A_C1, 32'h4081);
    rd_chk("R2", A_C1, 32'h4081);
    wr(A_F1, 1);
    rd_chk("R2", A_R1, 1);
    rd_chk("R2", A_F1, 1);
    ticks(1);
    rd_chk("R4", A_R1, 0);
    chk("R4", {30'd0, irq}, 32'h2);
    rd_chk("R3", A_R0, 10);
  endtask

  task automatic t_srst;
    wr(A_C0, 32'h40C1);
    wr(A_TOP, 32'h8000_0000);
    rd_chk("R10", A_C0, 0); rd_chk("R10", A_R0, 0); rd_chk("R10", A_F0, 0);
    rd_chk("R10", A_C1, 0); rd_chk("R10", A_F1, 0);
    chk("R10", {30'd0, irq}, 0);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_count;
    t_flag;
    t_oneshot;
    t_reload;
    t_readonly;
    t_wide;
    t_priority;
    t_chan1;
    t_srst;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule